// File: doc/BRIEF.md
# Infrared Transmit Waveform Player

This block drives an infrared transmit pin. The pin can follow one of three sources. The first is a queue of timed on/off descriptors loaded through a write port. The second is a single level bit under direct control. The third is the transmit line of a peripheral UART. Queued descriptors play back to back, timed by a one-cycle microsecond tick that the system clock domain supplies. One entry hands over to the next on a tick edge, so no gap and no glitch appears between entries.

When modulation is enabled, the active envelope is ANDed with a carrier from a programmable period/high-time counter on the system clock. The carrier restarts in phase at the start of every active descriptor. When modulation is off, the envelope drives the pin directly. The queue raises error flags for a descriptor with zero duration and for a descriptor that expires while the queue is empty (underrun).

The queue playback sequencer has two states. `ST_IDLE` waits for the play enable, the queue source and a non-empty queue. It then pops the head entry and takes the transition *load* to `ST_PLAY`. `ST_PLAY` counts down the loaded duration on ticks and has three transitions. *Chain* stays in `ST_PLAY` and loads the next entry on the terminal tick when the queue is not empty. *Starve* goes to `ST_IDLE` and sets the underrun flag on the terminal tick when the queue is empty. *Abort* goes to `ST_IDLE` and discards the current entry when play is disabled or the source changes.

Top module: `irtx_player`

## Requirements
- R1: `cfg_src` selects the envelope source. Code 0 selects the queue, 1 selects `cfg_bit`, 2 selects the UART line (active while `uart_txd` is low) and 3 selects none. While `cfg_play` is low, `ir_out` is low in the same cycle for every source.
- R2: A descriptor is 16 bits wide. Bit 15 is the level (1 = active) and bits 14:0 are the duration in microseconds. A descriptor loaded on a tick edge holds its level for exactly `duration` tick intervals.
- R3: When one descriptor ends and the queue holds another, the next one starts on that same tick edge. Two adjacent active entries give one unbroken high span.
- R4: A write whose duration field is zero is not queued, and `err_zero` is high for exactly the following cycle.
- R5: The queue holds 16 entries. `fifo_full` is high when all 16 are held, and a write while full is dropped.
- R6: `fifo_empty` is high when no entry is held, and `fifo_low` is high whenever the entry count is at most `thresh`.
- R7: If a descriptor ends while the queue is empty and play is enabled, `underrun` is set and stays set, and `ir_out` returns low. A flush clears `underrun`.
- R8: With `cfg_mod` high, an active descriptor gives `ir_out` high for the first `car_high` cycles of each `car_period`-cycle carrier period. The phase is counted from the cycle after the descriptor is loaded. A period of 0 acts as 1.
- R9: With `cfg_mod` low, `ir_out` equals the raw envelope of the selected source.
- R10: Dropping `cfg_play` or moving `cfg_src` away from the queue discards the descriptor that is playing and leaves the queued entries intact. Playback resumes with the next queued entry when play and the queue source return.
- R11: A pulse on `flush` empties the queue.
- R12: After reset, `ir_out`, `fifo_full`, `err_zero` and `underrun` are low and `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| cfg_play | input | 1 | Playback / output enable |
| cfg_src | input | 2 | Source select: 0 queue, 1 bit, 2 UART, 3 none |
| cfg_mod | input | 1 | Carrier modulation enable |
| cfg_bit | input | 1 | Direct output level |
| car_period | input | CAR_W | Carrier period in clock cycles |
| car_high | input | CAR_W | Carrier high time in clock cycles |
| thresh | input | LVL_W | Low-level threshold for `fifo_low` |
| wr_en | input | 1 | Descriptor write strobe |
| wr_data | input | 16 | Descriptor word |
| flush | input | 1 | Empty the queue, clear underrun |
| uart_txd | input | 1 | Peripheral UART transmit line |
| ir_out | output | 1 | Infrared output pin |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| fifo_low | output | 1 | Entry count at or below `thresh` |
| err_zero | output | 1 | Zero-duration write rejected (one-cycle pulse) |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench builds the block with its default 16-entry queue and an 8-bit carrier counter. It drives the microsecond tick every 4 clock cycles, so every playback interval is four cycles long. Each interval is sampled once, so a whole 16-entry fill plus one rejected overflow write plays out in a few hundred cycles. The small carrier width brings every period from 1 to 6 and every high time from 0 to the period into reach as one sweep. For each setting, the expected pattern is computed as (cycle mod period) < high.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    localparam int DESC_W = 16;
    localparam int DUR_W  = 15;

    typedef enum logic [1:0] {
        SRC_QUEUE = 2'd0,
        SRC_BIT   = 2'd1,
        SRC_UART  = 2'd2,
        SRC_OFF   = 2'd3
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PLAY = 1'b1
    } seq_st_e;

    typedef struct packed {
        logic             on;
        logic [DUR_W-1:0] dur;
    } desc_t;

endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
    parameter  int DEPTH = 16,
    parameter  int W     = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          flush,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R5: the entry count never passes the depth
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5: a full queue stays full until something leaves it
    a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full);

    // R11: flush leaves the queue empty
    a_r11_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] high,
    output logic          car_on
);

    logic [CW-1:0] cnt;
    logic [CW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign car_on  = (cnt < high);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         cnt <= '0;
        else if (restart)                   cnt <= '0;
        else if (cnt_inc >= {1'b0, period}) cnt <= '0;
        else                                cnt <= cnt_inc[CW-1:0];
    end

    // R8: a restart puts the carrier in its high phase on the next cycle
    a_r8_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && high != '0 && $stable(high)) |=> car_on);

endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
    import irtx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  us_tick,
    input  logic  run,
    input  logic  flush,
    input  desc_t head,
    input  logic  fifo_empty,
    output logic  pop,
    output logic  restart,
    output logic  env,
    output logic  underrun
);

    seq_st_e          state, state_n;
    logic [DUR_W-1:0] rem, rem_n;
    logic             lvl, lvl_n;
    logic             starve;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rem      <= '0;
            lvl      <= 1'b0;
            underrun <= 1'b0;
        end else begin
            state <= state_n;
            rem   <= rem_n;
            lvl   <= lvl_n;
            if (flush)       underrun <= 1'b0;
            else if (starve) underrun <= 1'b1;
        end
    end

    // next state and strobes
    always_comb begin
        state_n = state;
        rem_n   = rem;
        lvl_n   = lvl;
        pop     = 1'b0;
        restart = 1'b0;
        starve  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (run && !fifo_empty) begin
                    pop     = 1'b1;
                    restart = head.on;
                    lvl_n   = head.on;
                    rem_n   = head.dur;
                    state_n = ST_PLAY;
                end
            end
            ST_PLAY: begin
                if (!run) begin
                    state_n = ST_IDLE;
                    lvl_n   = 1'b0;
                end else if (us_tick) begin
                    if (rem != DUR_W'(1)) begin
                        rem_n = rem - 1'b1;
                    end else if (!fifo_empty) begin
                        pop     = 1'b1;
                        restart = head.on;
                        lvl_n   = head.on;
                        rem_n   = head.dur;
                    end else begin
                        starve  = 1'b1;
                        lvl_n   = 1'b0;
                        state_n = ST_IDLE;
                    end
                end
            end
        endcase
    end

    assign env = (state == ST_PLAY) && lvl;

    // R2: a playing descriptor always has time left
    a_r2_rem_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAY) |-> (rem != '0));

    // R3: a terminal tick with a queued entry keeps playing
    a_r3_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAY && run && us_tick && rem == DUR_W'(1) && !fifo_empty)
        |=> (state == ST_PLAY));

    // R7: expiry against an empty queue sets underrun and idles
    a_r7_starve: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAY && run && us_tick && rem == DUR_W'(1) && fifo_empty && !flush)
        |=> (underrun && state == ST_IDLE));

    // R10: losing play or source drops the current entry
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PLAY && !run) |=> (state == ST_IDLE));

endmodule

// File: rtl/irtx_player.sv
module irtx_player
    import irtx_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int CAR_W = 8,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              cfg_play,
    input  logic [1:0]        cfg_src,
    input  logic              cfg_mod,
    input  logic              cfg_bit,
    input  logic [CAR_W-1:0]  car_period,
    input  logic [CAR_W-1:0]  car_high,
    input  logic [LVL_W-1:0]  thresh,
    input  logic              wr_en,
    input  logic [DESC_W-1:0] wr_data,
    input  logic              flush,
    input  logic              uart_txd,
    output logic              ir_out,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              fifo_low,
    output logic              err_zero,
    output logic              underrun
);

    src_e              src;
    logic              run;
    logic              push, zero_wr;
    logic [DESC_W-1:0] head_raw;
    logic [LVL_W-1:0]  level;
    logic              pop, restart, q_env, car_on;
    logic              env;

    assign src     = src_e'(cfg_src);
    assign run     = cfg_play && (src == SRC_QUEUE);
    assign zero_wr = wr_en && (wr_data[DUR_W-1:0] == '0);
    assign push    = wr_en && !zero_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_zero <= 1'b0;
        else        err_zero <= zero_wr;
    end

    irtx_fifo #(.DEPTH(DEPTH), .W(DESC_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (wr_data),
        .pop   (pop),
        .flush (flush),
        .dout  (head_raw),
        .full  (fifo_full),
        .empty (fifo_empty),
        .count (level)
    );

    assign fifo_low = (level <= thresh);

    irtx_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick    (us_tick),
        .run        (run),
        .flush      (flush),
        .head       (desc_t'(head_raw)),
        .fifo_empty (fifo_empty),
        .pop        (pop),
        .restart    (restart),
        .env        (q_env),
        .underrun   (underrun)
    );

    irtx_carrier #(.CW(CAR_W)) u_car (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .period  (car_period),
        .high    (car_high),
        .car_on  (car_on)
    );

    always_comb begin
        unique case (src)
            SRC_QUEUE: env = q_env;
            SRC_BIT:   env = cfg_bit;
            SRC_UART:  env = !uart_txd;
            SRC_OFF:   env = 1'b0;
        endcase
    end

    assign ir_out = cfg_play && env && (cfg_mod ? car_on : 1'b1);

    // R1: disabled playback keeps the pin low
    a_r1_play_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_play |-> !ir_out);

    // R4: a zero-duration write flags an error next cycle
    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[DUR_W-1:0] == '0) |=> err_zero);

    // R4: a rejected write does not fill an empty queue
    a_r4_no_queue: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_empty && wr_en && wr_data[DUR_W-1:0] == '0 && !flush) |=> fifo_empty);

endmodule

// File: tb/irtx_player_bench.sv
module irtx_player_bench;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick;
    int          div;
    logic        cfg_play = 0, cfg_mod = 0, cfg_bit = 0, wr_en = 0, flush = 0, uart_txd = 1;
    logic [1:0]  cfg_src = 0;
    logic [7:0]  car_period = 8'd4, car_high = 8'd2;
    logic [4:0]  thresh = 5'd2;
    logic [15:0] wr_data = 0;
    logic        ir_out, fifo_full, fifo_empty, fifo_low, err_zero, underrun;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [15:0] dq [20];

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            div  <= 0;
            tick <= 1'b0;
        end else begin
            div  <= (div == DIV - 1) ? 0 : div + 1;
            tick <= (div == DIV - 1);
        end
    end

    irtx_player u_irtx_player (
        .clk(clk), .rst_n(rst_n), .us_tick(tick), .cfg_play(cfg_play),
        .cfg_src(cfg_src), .cfg_mod(cfg_mod), .cfg_bit(cfg_bit),
        .car_period(car_period), .car_high(car_high), .thresh(thresh),
        .wr_en(wr_en), .wr_data(wr_data), .flush(flush), .uart_txd(uart_txd),
        .ir_out(ir_out), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .fifo_low(fifo_low), .err_zero(err_zero), .underrun(underrun)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk);
        while (!tick) @(negedge clk);
        cfg_src  = 2'd0;
        cfg_play = 1'b1;
    endtask

    // Plays dq[0..n-1] and checks one sample per tick interval (R2, R3, R7)
    task automatic run_queue(input int n, input string req);
        int exp_iv [80];
        int m = 0;
        for (int i = 0; i < n; i++)
            for (int k = 0; k < int'(dq[i][14:0]); k++) begin
                exp_iv[m] = int'(dq[i][15]);
                m++;
            end
        arm();
        @(negedge clk);
        for (int j = 0; j < m; j++) begin
            check(req, $sformatf("interval %0d level", j), int'(ir_out), exp_iv[j]);
            while (!tick) @(negedge clk);
            @(negedge clk);
        end
        check("R7", "level after last entry", int'(ir_out), 0);
        check("R7", "underrun after last entry", int'(underrun), 1);
        cfg_play = 1'b0;
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog: actual=%0d expected=0 (cycles left)", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : stim
        int highs;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "ir_out", int'(ir_out), 0);
        check("R12", "fifo_empty", int'(fifo_empty), 1);
        check("R12", "fifo_full", int'(fifo_full), 0);
        check("R12", "err_zero", int'(err_zero), 0);
        check("R12", "underrun", int'(underrun), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 zero-duration rejection
        push(16'h8000);
        check("R4", "err_zero pulse", int'(err_zero), 1);
        check("R4", "queue still empty", int'(fifo_empty), 1);
        @(negedge clk);
        check("R4", "err_zero one cycle", int'(err_zero), 0);

        // R6 level flags, R5 fill to full and dropped overflow
        for (int i = 0; i < 16; i++) begin
            dq[i] = {1'(i % 2), 15'(1 + (i % 3))};
            push(dq[i]);
            if (i == 0) check("R6", "empty after one write", int'(fifo_empty), 0);
            if (i < 3)  check("R6", $sformatf("low at count %0d", i + 1), int'(fifo_low), (i + 1 <= 2) ? 1 : 0);
        end
        check("R5", "full at 16", int'(fifo_full), 1);
        push(16'h8007);
        check("R5", "full after overflow write", int'(fifo_full), 1);
        run_queue(16, "R2");
        check("R6", "empty after playback", int'(fifo_empty), 1);

        // R3 adjacent active entries, then off and on
        do_flush();
        check("R7", "flush clears underrun", int'(underrun), 0);
        dq[0] = 16'h8002; dq[1] = 16'h8003; dq[2] = 16'h0001; dq[3] = 16'h8001;
        for (int i = 0; i < 4; i++) push(dq[i]);
        run_queue(4, "R3");

        // R11 flush empties the queue
        do_flush();
        push(16'h8003); push(16'h8002); push(16'h8001);
        do_flush();
        check("R11", "empty after flush", int'(fifo_empty), 1);
        arm();
        highs = 0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            highs += int'(ir_out);
        end
        check("R11", "no output after flush", highs, 0);
        check("R11", "no underrun after flush", int'(underrun), 0);
        cfg_play = 1'b0;

        // R10 abort on source switch keeps the queue
        push(16'h8005); push(16'h0003);
        arm();
        @(negedge clk);
        check("R10", "first entry active", int'(ir_out), 1);
        cfg_bit = 1'b0;
        cfg_src = 2'd1;
        @(negedge clk);
        check("R10", "low after switch", int'(ir_out), 0);
        cfg_src = 2'd0;
        highs = 0;
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            highs += int'(ir_out);
        end
        check("R10", "aborted entry not resumed", highs, 0);
        check("R10", "next entry played to underrun", int'(underrun), 1);
        check("R10", "queue drained", int'(fifo_empty), 1);
        cfg_play = 1'b0;

        // R8 carrier sweep over period 1..6 and every high time
        for (int p = 1; p <= 6; p++) begin
            for (int h = 0; h <= p; h++) begin
                int bad = 0;
                push(16'h8003);
                @(negedge clk);
                car_period = 8'(p);
                car_high   = 8'(h);
                cfg_mod    = 1'b1;
                arm();
                for (int c = 0; c < 12; c++) begin
                    @(negedge clk);
                    if (int'(ir_out) != (((c % p) < h) ? 1 : 0)) bad++;
                end
                check("R8", $sformatf("carrier p=%0d h=%0d mismatches", p, h), bad, 0);
                cfg_play = 1'b0;
                cfg_mod  = 1'b0;
            end
        end

        // R1 and R9 bit and UART sources
        @(negedge clk);
        cfg_src = 2'd1; cfg_bit = 1'b1; cfg_play = 1'b1;
        @(negedge clk);
        check("R9", "bit source high", int'(ir_out), 1);
        cfg_bit = 1'b0;
        @(negedge clk);
        check("R9", "bit source low", int'(ir_out), 0);
        cfg_src = 2'd2; uart_txd = 1'b0;
        @(negedge clk);
        check("R1", "uart low drives active", int'(ir_out), 1);
        uart_txd = 1'b1;
        @(negedge clk);
        check("R1", "uart idle inactive", int'(ir_out), 0);
        uart_txd = 1'b0; cfg_play = 1'b0;
        @(negedge clk);
        check("R1", "play low forces low", int'(ir_out), 0);
        cfg_play = 1'b1; cfg_src = 2'd3;
        @(negedge clk);
        check("R1", "source none low", int'(ir_out), 0);
        cfg_src = 2'd1; cfg_bit = 1'b1; cfg_mod = 1'b1;
        car_period = 8'd4; car_high = 8'd2;
        repeat (6) @(negedge clk);
        highs = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            highs += int'(ir_out);
        end
        check("R8", "modulated bit source duty", highs, 4);
        cfg_play = 1'b0; cfg_mod = 1'b0; uart_txd = 1'b1;

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule